// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside an 8-bit processor core and decides which of five hardware interrupt sources the core should service next. One source is critical and cannot be masked or disabled. One source is captured on a rising edge. Two sources are sensed by level. The last source is a general request line. The three sources between the critical one and the general one each have a mask bit that is written as a group. A global enable gates every source except the critical one.

Each source has a fixed rank. While the winning source is not the general line, the block shows a pending flag and the 16-bit service address of that source. The general line has no fixed address. When it wins, the block raises an acknowledge request, so that the core can run an external acknowledge cycle instead of jumping to an address. The core pulses an accept strobe when it takes the interrupt. Accepting a maskable source clears the global enable. Accepting the general line also drives an active-low acknowledge output for one cycle.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the global enable is off, all three mask bits are set, the edge capture is empty, `ack_n` is 1 and `pend` is 0 with no request asserted; maskable requests do not pend.
- R2: Rank from highest to lowest: `crit_req`, edge source, `lvl_hi_req`, `lvl_lo_req`, `gen_req`; only the highest eligible source is reported.
- R3: Service addresses: edge source 0x003C, `lvl_hi_req` 0x0034, `lvl_lo_req` 0x002C; `vec_addr` is 0 when nothing is pending.
- R4: `crit_req` pends with address 0x0024 regardless of the global enable and the mask bits.
- R5: A mask write (`mask_wr`=1) loads `mask_bits`: bit 0 masks `lvl_lo_req`, bit 1 masks `lvl_hi_req`, bit 2 masks the edge source; a masked source does not pend.
- R6: A rising edge on `edge_req` is captured one clock later and stays pending after the line falls; after acceptance a line held high does not pend again until a new rising edge.
- R7: An edge is captured even while masked; a mask write with `mask_clr_edge`=1 discards the captured edge, and one with `mask_clr_edge`=0 keeps it.
- R8: `lvl_hi_req` and `lvl_lo_req` pend only while they are high.
- R9: When `gen_req` wins, `ack_req`=1, `pend`=1 and `vec_addr`=0; an accept in that cycle drives `ack_n` low for exactly the next cycle.
- R10: Accepting any maskable source clears the global enable; accepting `crit_req` leaves it unchanged.
- R11: `ien_set` turns the global enable on in the next cycle and `ien_clr` turns it off; when both are high, off wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crit_req | input | 1 | Critical request, not maskable, level |
| edge_req | input | 1 | Rising-edge request |
| lvl_hi_req | input | 1 | Upper level request |
| lvl_lo_req | input | 1 | Lower level request |
| gen_req | input | 1 | General request, no fixed address |
| mask_wr | input | 1 | Mask write strobe |
| mask_bits | input | 3 | Mask values: bit 2 edge, bit 1 upper level, bit 0 lower level |
| mask_clr_edge | input | 1 | Discard the captured edge on this mask write |
| ien_set | input | 1 | Turn the global enable on |
| ien_clr | input | 1 | Turn the global enable off |
| accept | input | 1 | The core takes the reported interrupt |
| pend | output | 1 | An eligible source is waiting |
| vec_addr | output | 16 | Service address of the winner, 0 if none or general |
| ack_req | output | 1 | The general line is the winner |
| ack_n | output | 1 | Active-low acknowledge, one cycle after the general line is accepted |

## Verification
The arbitration is driven with every source high, after which sources are removed one at a time. This shows that each rank sits in the right place and that each address is attached to its own source. Mask writes go through one bit at a time, each with a single source active, so a swap of two bit positions is seen. Edge tests use a one-cycle pulse, a masked pulse that is then unmasked with and without the clear bit, and a line held high after acceptance. These separate edge capture from level sensing. Accept tests cover a maskable source, the critical source and the general line, and tell apart enable clearing and acknowledge timing.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NUM_SRC   = 5;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int ADDR_W    = 16;
    localparam int NUM_MASK  = 3;

    // Rank order: lower index wins.
    localparam int SRC_CRIT  = 0;
    localparam int SRC_EDGE  = 1;
    localparam int SRC_LHI   = 2;
    localparam int SRC_LLO   = 3;
    localparam int SRC_GEN   = 4;

    function automatic logic [ADDR_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] v;
        case (idx)
            IDX_W'(SRC_CRIT): v = 16'h0024;
            IDX_W'(SRC_EDGE): v = 16'h003C;
            IDX_W'(SRC_LHI):  v = 16'h0034;
            IDX_W'(SRC_LLO):  v = 16'h002C;
            default:          v = '0;
        endcase
        return v;
    endfunction

    typedef struct packed {
        logic                ien;
        logic [NUM_MASK-1:0] mask;
        logic                ack_n;
    } ctl_state_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic prev;
        logic held;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req;
        if (clr)
            st_d.held = 1'b0;
        if (req && !st_q.prev)
            st_d.held = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flag = st_q.held;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N = 5,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] elig,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crit_req,
    input  logic              edge_req,
    input  logic              lvl_hi_req,
    input  logic              lvl_lo_req,
    input  logic              gen_req,
    input  logic              mask_wr,
    input  logic [2:0]        mask_bits,
    input  logic              mask_clr_edge,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              accept,
    output logic              pend,
    output logic [15:0]       vec_addr,
    output logic              ack_req,
    output logic              ack_n
);
    ctl_state_t st_d, st_q;

    logic               edge_flag;
    logic               edge_clr;
    logic [NUM_SRC-1:0] elig;
    logic               win_any;
    logic [IDX_W-1:0]   win_idx;
    logic               take;
    logic               ien_q;

    irq_edge_latch u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (edge_req),
        .clr   (edge_clr),
        .flag  (edge_flag)
    );

    always_comb begin
        elig           = '0;
        elig[SRC_CRIT] = crit_req;
        elig[SRC_EDGE] = edge_flag  && !st_q.mask[2] && st_q.ien;
        elig[SRC_LHI]  = lvl_hi_req && !st_q.mask[1] && st_q.ien;
        elig[SRC_LLO]  = lvl_lo_req && !st_q.mask[0] && st_q.ien;
        elig[SRC_GEN]  = gen_req    && st_q.ien;
    end

    irq_prio_sel #(.N(NUM_SRC)) u_sel (
        .elig (elig),
        .any  (win_any),
        .idx  (win_idx)
    );

    assign take     = accept && win_any;
    assign edge_clr = (take && win_idx == IDX_W'(SRC_EDGE)) ||
                      (mask_wr && mask_clr_edge);

    always_comb begin
        st_d       = st_q;
        st_d.ack_n = !(take && win_idx == IDX_W'(SRC_GEN));
        if (mask_wr)
            st_d.mask = mask_bits;
        if (ien_set)
            st_d.ien = 1'b1;
        if (ien_clr)
            st_d.ien = 1'b0;
        if (take && win_idx != IDX_W'(SRC_CRIT))
            st_d.ien = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ien   <= 1'b0;
            st_q.mask  <= '1;
            st_q.ack_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_q    = st_q.ien;
    assign pend     = win_any;
    assign ack_req  = win_any && win_idx == IDX_W'(SRC_GEN);
    assign vec_addr = win_any ? vector_of(win_idx) : '0;
    assign ack_n    = st_q.ack_n;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        crit_req,
    input logic        accept,
    input logic        ien_clr,
    input logic        pend,
    input logic [15:0] vec_addr,
    input logic        ack_req,
    input logic        ack_n,
    input logic        ien_q
);
    // R4
    crit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crit_req |-> (pend && vec_addr == 16'h0024));

    // R9
    gen_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (pend && vec_addr == 16'h0000 && !crit_req));

    // R9
    ack_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> $past(accept && ack_req));

    // R10
    maskable_take_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pend && !crit_req) |=> !ien_q);

    // R11
    ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_clr |=> !ien_q);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .crit_req (crit_req),
    .accept   (accept),
    .ien_clr  (ien_clr),
    .pend     (pend),
    .vec_addr (vec_addr),
    .ack_req  (ack_req),
    .ack_n    (ack_n),
    .ien_q    (ien_q)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit_req = 0, edge_req = 0, lvl_hi_req = 0, lvl_lo_req = 0, gen_req = 0;
    logic        mask_wr = 0, mask_clr_edge = 0, ien_set = 0, ien_clr = 0, accept = 0;
    logic [2:0]  mask_bits = '0;
    logic        pend, ack_req, ack_n;
    logic [15:0] vec_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_ctrl i_irq_vec_ctrl (
        .clk(clk), .rst_n(rst_n),
        .crit_req(crit_req), .edge_req(edge_req), .lvl_hi_req(lvl_hi_req),
        .lvl_lo_req(lvl_lo_req), .gen_req(gen_req),
        .mask_wr(mask_wr), .mask_bits(mask_bits), .mask_clr_edge(mask_clr_edge),
        .ien_set(ien_set), .ien_clr(ien_clr), .accept(accept),
        .pend(pend), .vec_addr(vec_addr), .ack_req(ack_req), .ack_n(ack_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled after the falling edge.
    task automatic cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_mask(input logic [2:0] m, input logic clr);
        mask_wr = 1; mask_bits = m; mask_clr_edge = clr;
        cycle();
        mask_wr = 0; mask_clr_edge = 0;
    endtask

    task automatic enable();
        ien_set = 1; cycle(); ien_set = 0;
    endtask

    task automatic take();
        accept = 1; cycle(); accept = 0;
    endtask

    task automatic t_reset();
        chk("R1 pend", pend, 0);
        chk("R1 ack_n", ack_n, 1);
        chk("R3 idle addr", vec_addr, 0);
        gen_req = 1; lvl_lo_req = 1; cycle();
        chk("R1 masked/disabled", pend, 0);
        crit_req = 1; #1;
        chk("R4 crit pend", pend, 1);
        chk("R4 crit addr", vec_addr, 32'h0024);
        crit_req = 0; gen_req = 0; lvl_lo_req = 0; cycle();
    endtask

    task automatic t_enable();
        wr_mask(3'b000, 1'b1);
        gen_req = 1; #1;
        chk("R11 still off", pend, 0);
        enable();
        chk("R11 on", pend, 1);
        chk("R9 ack_req", ack_req, 1);
        chk("R9 addr zero", vec_addr, 0);
        ien_clr = 1; cycle(); ien_clr = 0;
        chk("R11 off", pend, 0);
        ien_set = 1; ien_clr = 1; cycle(); ien_set = 0; ien_clr = 0;
        chk("R11 clr wins", pend, 0);
        gen_req = 0;
    endtask

    task automatic t_levels();
        enable();
        lvl_lo_req = 1; #1;
        chk("R3 lo addr", vec_addr, 32'h002C);
        lvl_hi_req = 1; #1;
        chk("R2 hi over lo", vec_addr, 32'h0034);
        wr_mask(3'b010, 1'b0);
        chk("R5 bit1 masks hi", vec_addr, 32'h002C);
        wr_mask(3'b011, 1'b0);
        chk("R5 bit0 masks lo", pend, 0);
        wr_mask(3'b000, 1'b0);
        chk("R8 level pends", vec_addr, 32'h0034);
        lvl_hi_req = 0; lvl_lo_req = 0; #1;
        chk("R8 level drop", pend, 0);
    endtask

    task automatic t_edge();
        edge_req = 1; cycle(); edge_req = 0; cycle();
        chk("R6 held after fall", pend, 1);
        chk("R3 edge addr", vec_addr, 32'h003C);
        take();
        chk("R6 cleared by take", pend, 0);
        gen_req = 1; #1;
        chk("R10 enable cleared", pend, 0);
        gen_req = 0;
        enable();
        edge_req = 1; cycle();
        chk("R6 new edge", pend, 1);
        take(); enable(); cycle();
        chk("R6 held high no repeat", pend, 0);
        edge_req = 0; cycle();
    endtask

    task automatic t_edge_clr();
        wr_mask(3'b100, 1'b0);
        edge_req = 1; cycle(); edge_req = 0; cycle();
        chk("R5 bit2 masks edge", pend, 0);
        wr_mask(3'b000, 1'b0);
        chk("R7 kept while masked", vec_addr, 32'h003C);
        wr_mask(3'b000, 1'b1);
        chk("R7 clear bit", pend, 0);
    endtask

    task automatic t_prio();
        edge_req = 1; cycle(); edge_req = 0;
        crit_req = 1; lvl_hi_req = 1; lvl_lo_req = 1; gen_req = 1; #1;
        chk("R2 crit top", vec_addr, 32'h0024);
        crit_req = 0; #1;
        chk("R2 edge next", vec_addr, 32'h003C);
        wr_mask(3'b000, 1'b1);
        chk("R2 hi next", vec_addr, 32'h0034);
        lvl_hi_req = 0; #1;
        chk("R2 lo next", vec_addr, 32'h002C);
        lvl_lo_req = 0; #1;
        chk("R2 gen last", ack_req, 1);
    endtask

    task automatic t_gen_ack();
        chk("R9 ack_n idle", ack_n, 1);
        take();
        chk("R9 ack_n low", ack_n, 0);
        cycle();
        chk("R9 ack_n one cycle", ack_n, 1);
        chk("R10 gen take clears enable", pend, 0);
        gen_req = 0;
    endtask

    task automatic t_crit_take();
        enable();
        crit_req = 1; #1;
        take();
        crit_req = 0; gen_req = 1; #1;
        chk("R10 crit keeps enable", pend, 1);
        chk("R4 no ack after crit", ack_n, 1);
        gen_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cycle(); cycle();
        rst_n = 1;
        cycle();
        t_reset();
        t_enable();
        t_levels();
        t_edge();
        t_edge_clr();
        t_prio();
        t_gen_ack();
        t_crit_take();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule